// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the control-memory address a microprogrammed controller will read next. It keeps a 7-bit control address and a 7-bit single-level return address. Every rising clock edge it replaces the control address with one of four sources: the current address plus one, the address field of the current microinstruction, the saved return address, or an address formed from the opcode bits of the data register.

The current microinstruction supplies a 2-bit test select, a 2-bit branch kind and a 7-bit target address. The datapath supplies three status flags (indirect bit, accumulator sign, accumulator zero) and the four opcode bits. A small encoder turns the branch kind and the selected test bit into a 2-bit source select and a save strobe for the return register. The control-memory contents and the datapath sit outside the block. The current control address and the saved return address both appear as outputs.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `ctl_addr` to 64 and `ret_addr` to 0 at the next rising edge, taking priority over all other inputs.
- R2: `tst_sel` chooses the test bit: 0 gives constant 1, 1 gives `flag_ind`, 2 gives `flag_sign`, 3 gives `flag_zero`.
- R3: With `br_kind` = 0 (jump), `ctl_addr` takes `br_target` when the test bit is 1 and becomes `ctl_addr`+1 when it is 0.
- R4: With `br_kind` = 1 (call) and the test bit 1, `ctl_addr` takes `br_target` and `ret_addr` takes the old `ctl_addr`+1 on the same edge; with the test bit 0, `ctl_addr` becomes `ctl_addr`+1 and `ret_addr` keeps its value.
- R5: With `br_kind` = 2 (return), `ctl_addr` takes `ret_addr` whatever the test bit, and `ret_addr` keeps its value.
- R6: With `br_kind` = 3 (map), `ctl_addr` becomes `{0, op_bits[3:0], 00}` (that is, `op_bits`×4) whatever the test bit, and `ret_addr` keeps its value.
- R7: The increment wraps modulo 128: address 127 plus one gives 0, both for `ctl_addr` and for the value saved by a call.
- R8: `ret_addr` changes only on a taken call. It holds one level: a second taken call overwrites it, and repeated returns all go to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| tst_sel | input | 2 | Test-bit select field of the current microinstruction |
| br_kind | input | 2 | Branch-kind field of the current microinstruction |
| br_target | input | 7 | Address field of the current microinstruction |
| flag_ind | input | 1 | Indirect bit from the data register |
| flag_sign | input | 1 | Accumulator sign bit |
| flag_zero | input | 1 | Accumulator equals zero |
| op_bits | input | 4 | Opcode bits of the data register |
| ctl_addr | output | 7 | Current control-memory address |
| ret_addr | output | 7 | Saved return address |

## Verification
A taken call does two things on a single edge: it loads the control address from the target field and writes the incremented old address into the return register. The bench provokes the worst case by jumping to address 127 and then issuing an unconditional call, so the saved value must be the wrapped 0 while the control address lands on the target. A following return must then land on 0, which shows both halves of that edge were correct and that the increment wraps in the saved path as well as the in-line path.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Branch kind field of a microinstruction; the bit pattern feeds the
    // select encoder directly, so the values are fixed.
    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_kind_e;

    // Test-bit select field.
    typedef enum logic [1:0] {
        TST_ONE  = 2'b00,
        TST_IND  = 2'b01,
        TST_SIGN = 2'b10,
        TST_ZERO = 2'b11
    } tst_sel_e;

    // Next-address source, in multiplexer input order.
    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_TARGET = 2'b01,
        SRC_RET    = 2'b10,
        SRC_MAP    = 2'b11
    } src_sel_e;

endpackage

// File: rtl/useq_test_mux.sv
module useq_test_mux
    import useq_pkg::*;
(
    input  tst_sel_e sel,
    input  logic     flag_ind,
    input  logic     flag_sign,
    input  logic     flag_zero,
    output logic     test
);

    always_comb begin
        unique case (sel)
            TST_ONE:  test = 1'b1;
            TST_IND:  test = flag_ind;
            TST_SIGN: test = flag_sign;
            TST_ZERO: test = flag_zero;
            default:  test = 1'b1;
        endcase
    end

    // R2: the constant select must always report a set test bit
    always_comb begin
        if (sel == TST_ONE) begin
            a_r2_const_one: assert (test == 1'b1);
        end
    end

endmodule

// File: rtl/useq_select_enc.sv
module useq_select_enc
    import useq_pkg::*;
(
    input  br_kind_e kind,
    input  logic     test,
    output src_sel_e src,
    output logic     save_ret
);

    logic i1;
    logic i0;
    logic s1;
    logic s0;

    always_comb begin
        i1       = kind[1];
        i0       = kind[0];
        s1       = i1;
        s0       = (i0 & i1) | (~i1 & test);
        save_ret = ~i1 & i0 & test;
        src      = src_sel_e'({s1, s0});
    end

    // R4: the return register is written only while the target is selected
    always_comb begin
        if (save_ret) begin
            a_r4_save_with_target: assert (src == SRC_TARGET);
        end
        // R5 / R6: return and map ignore the test bit
        if (kind == BR_RET) begin
            a_r5_ret_source: assert (src == SRC_RET);
        end
        if (kind == BR_MAP) begin
            a_r6_map_source: assert (src == SRC_MAP);
        end
    end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int OP_W      = 4,
    parameter int MAP_SHIFT = 2
) (
    input  src_sel_e            src,
    input  logic [ADDR_W-1:0]   cur,
    input  logic [ADDR_W-1:0]   target,
    input  logic [ADDR_W-1:0]   ret,
    input  logic [OP_W-1:0]     op,
    output logic [ADDR_W-1:0]   inc,
    output logic [ADDR_W-1:0]   nxt
);

    localparam int MAP_TOP = OP_W + MAP_SHIFT;

    logic [ADDR_W-1:0] mapped;

    // Opcode placement: low bits zero, opcode above them, remaining top
    // bits zero. The variant depends on whether the layout fills the word.
    generate
        if (MAP_TOP < ADDR_W) begin : g_map_pad
            assign mapped = {{(ADDR_W - MAP_TOP){1'b0}}, op, {MAP_SHIFT{1'b0}}};
        end else begin : g_map_full
            logic [MAP_TOP-1:0] wide;
            assign wide   = {op, {MAP_SHIFT{1'b0}}};
            assign mapped = wide[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        inc = cur + 1'b1;
        unique case (src)
            SRC_INC:    nxt = inc;
            SRC_TARGET: nxt = target;
            SRC_RET:    nxt = ret;
            SRC_MAP:    nxt = mapped;
            default:    nxt = inc;
        endcase
    end

    // R7: the incrementer wraps from the top address to zero
    always_comb begin
        if (&cur) begin
            a_r7_wrap: assert (inc == '0);
        end
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int MAP_SHIFT  = 2,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        tst_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              flag_ind,
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic [OP_W-1:0]   op_bits,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam logic [ADDR_W-1:0] START = ADDR_W'(RESET_ADDR);

    typedef struct packed {
        logic [ADDR_W-1:0] ctl;
        logic [ADDR_W-1:0] ret;
    } seq_state_t;

    seq_state_t state_d;
    seq_state_t state_q;

    tst_sel_e          sel_w;
    br_kind_e          kind_w;
    logic              test_w;
    src_sel_e          src_w;
    logic              save_w;
    logic [ADDR_W-1:0] inc_w;
    logic [ADDR_W-1:0] nxt_w;

    assign sel_w  = tst_sel_e'(tst_sel);
    assign kind_w = br_kind_e'(br_kind);

    useq_test_mux u_test (
        .sel       (sel_w),
        .flag_ind  (flag_ind),
        .flag_sign (flag_sign),
        .flag_zero (flag_zero),
        .test      (test_w)
    );

    useq_select_enc u_enc (
        .kind     (kind_w),
        .test     (test_w),
        .src      (src_w),
        .save_ret (save_w)
    );

    useq_next_addr #(
        .ADDR_W    (ADDR_W),
        .OP_W      (OP_W),
        .MAP_SHIFT (MAP_SHIFT)
    ) u_next (
        .src    (src_w),
        .cur    (state_q.ctl),
        .target (br_target),
        .ret    (state_q.ret),
        .op     (op_bits),
        .inc    (inc_w),
        .nxt    (nxt_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.ctl = nxt_w;
        if (save_w) begin
            state_d.ret = inc_w;
        end
        if (rst) begin
            state_d.ctl = START;
            state_d.ret = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign ctl_addr = state_q.ctl;
    assign ret_addr = state_q.ret;

    // R3: an unconditional jump lands on the target field
    a_r3_jump_uncond: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && tst_sel == 2'b00) |=> ctl_addr == $past(br_target));

    // R4: a taken call stores the following address
    a_r4_call_saves: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && test_w) |=> ret_addr == ADDR_W'($past(ctl_addr) + 1'b1));

    // R5: a return resumes at the saved address
    a_r5_return: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10) |=> ctl_addr == $past(ret_addr));

    // R6: map places the opcode above two zero bits
    a_r6_map_addr: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11) |=> ctl_addr == (ADDR_W'($past(op_bits)) << MAP_SHIFT));

    // R8: the return register is untouched unless a call is taken
    a_r8_ret_hold: assert property (@(posedge clk) disable iff (rst)
        !(br_kind == 2'b01 && test_w) |=> $stable(ret_addr));

endmodule

// File: tb/useq_sequencer_test.sv
`timescale 1ns/1ps
module useq_sequencer_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] tst_sel;
    logic [1:0] br_kind;
    logic [6:0] br_target;
    logic       flag_ind;
    logic       flag_sign;
    logic       flag_zero;
    logic [3:0] op_bits;
    logic [6:0] ctl_addr;
    logic [6:0] ret_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    useq_sequencer uut (
        .clk       (clk),
        .rst       (rst),
        .tst_sel   (tst_sel),
        .br_kind   (br_kind),
        .br_target (br_target),
        .flag_ind  (flag_ind),
        .flag_sign (flag_sign),
        .flag_zero (flag_zero),
        .op_bits   (op_bits),
        .ctl_addr  (ctl_addr),
        .ret_addr  (ret_addr)
    );

    // Vector: req(4) rst(1) tst(2) br(2) target(7) ind sign zero op(4) exp_ctl(7) exp_ret(7)
    localparam int NV = 21;
    localparam logic [36:0] VEC [NV] = '{
        {4'd1, 1'b1, 2'd0, 2'd0, 7'd0,   1'b0,1'b0,1'b0, 4'd0,  7'd64,  7'd0 },  // R1 reset
        {4'd3, 1'b0, 2'd0, 2'd0, 7'd65,  1'b0,1'b0,1'b0, 4'd0,  7'd65,  7'd0 },  // R3 jump U
        {4'd2, 1'b0, 2'd1, 2'd0, 7'd10,  1'b0,1'b1,1'b1, 4'd0,  7'd66,  7'd0 },  // R2 ind=0 falls through
        {4'd2, 1'b0, 2'd1, 2'd0, 7'd10,  1'b1,1'b0,1'b0, 4'd0,  7'd10,  7'd0 },  // R2 ind=1 taken
        {4'd2, 1'b0, 2'd2, 2'd0, 7'd20,  1'b0,1'b1,1'b0, 4'd0,  7'd20,  7'd0 },  // R2 sign taken
        {4'd2, 1'b0, 2'd3, 2'd0, 7'd40,  1'b1,1'b1,1'b0, 4'd0,  7'd21,  7'd0 },  // R2 zero=0 falls
        {4'd2, 1'b0, 2'd3, 2'd0, 7'd40,  1'b0,1'b0,1'b1, 4'd0,  7'd40,  7'd0 },  // R2 zero taken
        {4'd4, 1'b0, 2'd1, 2'd1, 7'd67,  1'b1,1'b0,1'b0, 4'd0,  7'd67,  7'd41},  // R4 call taken
        {4'd4, 1'b0, 2'd2, 2'd1, 7'd5,   1'b1,1'b0,1'b1, 4'd0,  7'd68,  7'd41},  // R4 call not taken
        {4'd6, 1'b0, 2'd1, 2'd3, 7'd99,  1'b0,1'b0,1'b0, 4'd5,  7'd20,  7'd41},  // R6 map, test 0
        {4'd5, 1'b0, 2'd3, 2'd2, 7'd99,  1'b0,1'b0,1'b0, 4'd0,  7'd41,  7'd41},  // R5 return, test 0
        {4'd6, 1'b0, 2'd0, 2'd3, 7'd0,   1'b0,1'b0,1'b0, 4'd15, 7'd60,  7'd41},  // R6 map top opcode
        {4'd4, 1'b0, 2'd0, 2'd1, 7'd70,  1'b0,1'b0,1'b0, 4'd0,  7'd70,  7'd61},  // R4 call U
        {4'd8, 1'b0, 2'd0, 2'd1, 7'd80,  1'b0,1'b0,1'b0, 4'd0,  7'd80,  7'd71},  // R8 nested overwrites
        {4'd5, 1'b0, 2'd0, 2'd2, 7'd0,   1'b0,1'b0,1'b0, 4'd0,  7'd71,  7'd71},  // R5 return
        {4'd8, 1'b0, 2'd0, 2'd2, 7'd0,   1'b0,1'b0,1'b0, 4'd0,  7'd71,  7'd71},  // R8 single level
        {4'd3, 1'b0, 2'd0, 2'd0, 7'd127, 1'b0,1'b0,1'b0, 4'd0,  7'd127, 7'd71},  // R3 jump to top
        {4'd7, 1'b0, 2'd1, 2'd0, 7'd9,   1'b0,1'b0,1'b0, 4'd0,  7'd0,   7'd71},  // R7 in-line wrap
        {4'd3, 1'b0, 2'd0, 2'd0, 7'd127, 1'b0,1'b0,1'b0, 4'd0,  7'd127, 7'd71},  // R3 jump to top
        {4'd7, 1'b0, 2'd0, 2'd1, 7'd3,   1'b0,1'b0,1'b0, 4'd0,  7'd3,   7'd0 },  // R7 call saves wrapped
        {4'd7, 1'b0, 2'd0, 2'd2, 7'd0,   1'b0,1'b0,1'b0, 4'd0,  7'd0,   7'd0 }   // R7 return to 0
    };

    task automatic check(input string req, input logic [6:0] exp_c, input logic [6:0] exp_r);
        n_checks++;
        if (ctl_addr !== exp_c || ret_addr !== exp_r) begin
            n_fails++;
            $display("FAIL %s: ctl_addr=%0d ret_addr=%0d expected ctl_addr=%0d ret_addr=%0d",
                     req, ctl_addr, ret_addr, exp_c, exp_r);
        end
    endtask

    task automatic drive(input logic r, input logic [1:0] t, input logic [1:0] b,
                         input logic [6:0] tg, input logic [3:0] op);
        rst = r; tst_sel = t; br_kind = b; br_target = tg; op_bits = op;
        flag_ind = 1'b0; flag_sign = 1'b0; flag_zero = 1'b0;
    endtask

    initial begin
        drive(1'b1, 2'd0, 2'd0, 7'd0, 4'd0);
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            rst       = v[32];
            tst_sel   = v[31:30];
            br_kind   = v[29:28];
            br_target = v[27:21];
            flag_ind  = v[20];
            flag_sign = v[19];
            flag_zero = v[18];
            op_bits   = v[17:14];
            @(negedge clk);
            check($sformatf("R%0d vector %0d", v[36:33], i), v[13:7], v[6:0]);
        end

        // R1: reset wins over a taken call in the same cycle
        drive(1'b0, 2'd0, 2'd1, 7'd90, 4'd0);
        @(negedge clk);
        check("R4 call before reset", 7'd90, 7'd1);
        drive(1'b1, 2'd0, 2'd1, 7'd33, 4'd9);
        @(negedge clk);
        check("R1 reset over call", 7'd64, 7'd0);

        // R1: held reset keeps the start state
        @(negedge clk);
        check("R1 reset held", 7'd64, 7'd0);

        // R6: map with every flag set still uses only the opcode
        drive(1'b0, 2'd3, 2'd3, 7'd1, 4'd1);
        flag_ind = 1'b1; flag_sign = 1'b1; flag_zero = 1'b1;
        @(negedge clk);
        check("R6 map flags ignored", 7'd4, 7'd0);

        // R3: a failing test on jump increments
        drive(1'b0, 2'd2, 2'd0, 7'd50, 4'd0);
        @(negedge clk);
        check("R3 jump not taken", 7'd5, 7'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule